// File: doc/BRIEF.md
# Lockable LRU Set-Associative Tag Controller

This block is the tag and replacement engine of a set-associative cache. Each request carries a line address (the byte address with the line-offset bits already dropped) and an operation: load, store, lock, unlock, invalidate one line, or invalidate everything. The block looks the line up in its tag store and answers one clock after it accepts the request. The answer gives hit or miss, the way involved, whether the access has to bypass the cache, and whether a store goes to the line, to memory, or to both. For every way it keeps a valid flag, a dirty flag, a lock flag and a recency rank. Replacement picks the unlocked way with the lowest rank.

Line data and the memory port are outside the block. When a line has to be written back or refilled, the block raises a valid/ready request toward a refill engine. A write-back always completes before the matching refill. The block reports busy and accepts no new request until all such traffic is done. A copy-back/write-through mode input sets the store and eviction policy. A direct-mapped mode input turns the array into a one-way cache with SETS×WAYS sets.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset no line is valid, no line is dirty or locked, all ranks are zero, and `busy`, `rsp_valid`, `wb_valid`, `fill_valid`, `hit_count` and `access_count` are all low.
- R2: The set index is the low SET_W bits of `req_line` and the tag is the remaining upper bits. A request accepted on one clock edge (`req_valid` high, `busy` low) has its response on the next edge, with `rsp_valid` high for one cycle. A hit reports `rsp_hit`=1 and the matching way on `rsp_way`.
- R3: On a miss the victim is the unlocked way with the smallest rank, the lowest way index winning ties. If every candidate way is locked, `rsp_bypass`=1, no line is allocated and no refill is requested.
- R4: When a way is touched (hit, or allocated by a load, store or lock), every other way of the set whose rank exceeds the touched way's old rank loses one, and the touched way's rank becomes WAYS.
- R5: An invalidate (op code 4) that hits clears the line's valid, dirty and lock flags. Every other way of the set with a nonzero rank below the line's old rank gains one, and the line's rank becomes 0. With `req_flush`=1 the line is written back only if it is dirty.
- R6: A store (op code 1) that hits, or that misses in copy-back mode (`copy_back`=1) with a victim available, sets `rsp_line_wr`. It sets the dirty flag only in copy-back mode. A store in write-through mode, or one with no victim, sets `rsp_mem_wr`. A write-through miss allocates nothing.
- R7: When a miss allocates a line, a valid dirty victim is first written back at {old tag, set} only in copy-back mode. A refill of the requested line into the victim way is then requested on `fill_addr`/`fill_way`.
- R8: A lock (op code 2) behaves as a load lookup and sets the line's lock flag. An unlock (op code 3) that hits clears the lock flag and leaves the ranks unchanged. A load has op code 0.
- R9: Invalidate-all (op code 5) walks every line, set by set and way by way within a set, one line per cycle. It clears every flag and rank. With `req_flush`=1 each valid dirty line is written back in walk order.
- R10: With `one_way`=1 the index is the low SET_W+WAY_W bits of `req_line`. Its upper WAY_W bits select the single way that may hit or be the victim, so the array acts as a direct-mapped cache.
- R11: While `busy` is high, requests are ignored. `wb_valid` and `fill_valid` hold their address stable until their ready is seen. A write-back always completes before the refill of the same request.
- R12: `access_count` counts accepted loads and stores and `hit_count` counts those that hit. Both stop at their maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | 0 load, 1 store, 2 lock, 3 unlock, 4 invalidate, 5 invalidate-all |
| req_line | input | ADDR_W-OFF_W | Line address of the request |
| req_flush | input | 1 | Write back dirty data on invalidate |
| copy_back | input | 1 | 1 copy-back, 0 write-through |
| one_way | input | 1 | Direct-mapped mode |
| busy | output | 1 | Request input blocked |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hit way, else allocated way, else 0 |
| rsp_bypass | output | 1 | No unlocked way available |
| rsp_line_wr | output | 1 | Store data goes into the line |
| rsp_mem_wr | output | 1 | Store data goes to memory |
| wb_valid | output | 1 | Write-back request |
| wb_addr | output | ADDR_W-OFF_W | Line address to write back |
| wb_ready | input | 1 | Write-back accepted |
| fill_valid | output | 1 | Refill request |
| fill_addr | output | ADDR_W-OFF_W | Line address to refill |
| fill_way | output | WAY_W | Way receiving the refill |
| fill_ready | input | 1 | Refill accepted |
| hit_count | output | CNT_W | Saturating hit counter |
| access_count | output | CNT_W | Saturating access counter |

## Verification
A corrupted rank or lock flag does not show at once. It first shows on the next miss to the same set, as a wrong `rsp_way` and `fill_way` or a wrong `rsp_bypass` one clock after acceptance. A stale dirty or valid flag shows as a missing, extra or misaddressed `wb_addr` during the handshake phase of a later eviction, invalidate or walk. The reference model tracks every flag and rank, and chosen sequences drive each set into such a miss soon after each state change, so a fault appears within a few requests.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
   typedef enum logic [2:0] {
      OP_LOAD      = 3'd0,
      OP_STORE     = 3'd1,
      OP_LOCK      = 3'd2,
      OP_UNLOCK    = 3'd3,
      OP_INVAL     = 3'd4,
      OP_INVAL_ALL = 3'd5
   } ctag_op_e;
endpackage

// File: rtl/ctag_match.sv
module ctag_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 20,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
   input  logic [WAYS-1:0]            way_valid,
   input  logic [WAYS-1:0]            way_en,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] hit_vec;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_valid[g] & way_en[g] & (way_tags[g] == look_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (hit_vec[i]) hit_way = WAY_W'(i);
   end
endmodule

// File: rtl/ctag_victim.sv
module ctag_victim #(
   parameter int WAYS = 2,
   parameter int RK_W = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][RK_W-1:0] ranks,
   input  logic [WAYS-1:0]           cand,
   output logic                      found,
   output logic [WAY_W-1:0]          victim
);
   logic [RK_W-1:0] best;

   always_comb begin
      found  = 1'b0;
      victim = '0;
      best   = '1;
      for (int i = 0; i < WAYS; i++) begin
         if (cand[i] && (!found || ranks[i] < best)) begin
            found  = 1'b1;
            victim = WAY_W'(i);
            best   = ranks[i];
         end
      end
   end
endmodule

// File: rtl/ctag_rank.sv
module ctag_rank #(
   parameter int WAYS = 2,
   parameter int RK_W = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][RK_W-1:0] ranks_in,
   input  logic [WAY_W-1:0]          sel,
   input  logic                      demote,
   output logic [WAYS-1:0][RK_W-1:0] ranks_out
);
   logic [RK_W-1:0] pivot;
   assign pivot = ranks_in[sel];

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      always_comb begin
         if (sel == WAY_W'(g))
            ranks_out[g] = demote ? '0 : RK_W'(WAYS);
         else if (demote)
            ranks_out[g] = (ranks_in[g] != '0 && ranks_in[g] < pivot) ?
                           RK_W'(ranks_in[g] + 1'b1) : ranks_in[g];
         else
            ranks_out[g] = (ranks_in[g] > pivot) ?
                           RK_W'(ranks_in[g] - 1'b1) : ranks_in[g];
      end
   end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
   import ctag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 2,
   parameter int LINE_BYTES = 32,
   parameter int CNT_W      = 16,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int TAG_W  = LA_W - SET_W,
   localparam int RK_W   = $clog2(WAYS + 1),
   localparam int LINE_W = SET_W + WAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [LA_W-1:0]   req_line,
   input  logic              req_flush,
   input  logic              copy_back,
   input  logic              one_way,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic              rsp_bypass,
   output logic              rsp_line_wr,
   output logic              rsp_mem_wr,
   output logic              wb_valid,
   output logic [LA_W-1:0]   wb_addr,
   input  logic              wb_ready,
   output logic              fill_valid,
   output logic [LA_W-1:0]   fill_addr,
   output logic [WAY_W-1:0]  fill_way,
   input  logic              fill_ready,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  access_count
);
   // elaboration-time parameter checks
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   // state storage
   logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
   logic [WAYS-1:0][RK_W-1:0]  rank_q  [SETS];
   logic [WAYS-1:0]            val_q   [SETS];
   logic [WAYS-1:0]            dirty_q [SETS];
   logic [WAYS-1:0]            lock_q  [SETS];

   logic              walking, walk_flush, fill_wait;
   logic [LINE_W-1:0] walk_idx;
   logic [SET_W-1:0]  w_set;
   logic [WAY_W-1:0]  w_way;
   assign w_set = walk_idx[LINE_W-1:WAY_W];
   assign w_way = walk_idx[WAY_W-1:0];

   // request decode
   ctag_op_e          op;
   logic [SET_W-1:0]  l_set;
   logic [TAG_W-1:0]  l_tag;
   logic [WAY_W-1:0]  dm_way;
   logic [WAYS-1:0]   way_en;
   logic              accept, is_lookup, is_store;

   assign op        = ctag_op_e'(req_op);
   assign busy      = walking | wb_valid | fill_valid | fill_wait;
   assign accept    = req_valid & ~busy;
   assign l_set     = req_line[SET_W-1:0];
   assign l_tag     = req_line[LA_W-1 -: TAG_W];
   assign dm_way    = req_line[SET_W +: WAY_W];
   assign way_en    = one_way ? (WAYS'(1) << dm_way) : '1;
   assign is_lookup = (op == OP_LOAD) | (op == OP_STORE) | (op == OP_LOCK);
   assign is_store  = (op == OP_STORE);

   // lookup, victim choice, rank update
   logic             hit_raw, hit, vic_found;
   logic [WAY_W-1:0] hit_way, victim, tw;
   logic [WAYS-1:0][RK_W-1:0] new_ranks;

   ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .way_tags (tag_q[l_set]),
      .way_valid(val_q[l_set]),
      .way_en   (way_en),
      .look_tag (l_tag),
      .hit      (hit_raw),
      .hit_way  (hit_way)
   );

   ctag_victim #(.WAYS(WAYS), .RK_W(RK_W)) u_victim (
      .ranks (rank_q[l_set]),
      .cand  (way_en & ~lock_q[l_set]),
      .found (vic_found),
      .victim(victim)
   );

   assign hit = hit_raw & (is_lookup | (op == OP_UNLOCK) | (op == OP_INVAL));
   assign tw  = hit ? hit_way : victim;

   ctag_rank #(.WAYS(WAYS), .RK_W(RK_W)) u_rank (
      .ranks_in (rank_q[l_set]),
      .sel      (tw),
      .demote   (op == OP_INVAL),
      .ranks_out(new_ranks)
   );

   logic alloc, bypass, rank_we, wb_alloc, wb_inval, line_wr, mem_wr;
   assign alloc    = is_lookup & ~hit & vic_found & (~is_store | copy_back);
   assign bypass   = is_lookup & ~hit & ~vic_found;
   assign rank_we  = (is_lookup & (hit | alloc)) | ((op == OP_INVAL) & hit);
   assign wb_alloc = alloc & val_q[l_set][victim] & dirty_q[l_set][victim] & copy_back;
   assign wb_inval = (op == OP_INVAL) & hit & req_flush & dirty_q[l_set][hit_way];
   assign line_wr  = is_store & (hit | alloc);
   assign mem_wr   = is_store & (~copy_back | (~hit & ~vic_found));

   // tag array (no reset needed: valid flags gate every use)
   always_ff @(posedge clk) begin
      if (accept && alloc) tag_q[l_set][victim] <= l_tag;
   end

   // flag, rank and walk state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            val_q[i]   <= '0;
            dirty_q[i] <= '0;
            lock_q[i]  <= '0;
            rank_q[i]  <= '0;
         end
         walking    <= 1'b0;
         walk_flush <= 1'b0;
         walk_idx   <= '0;
      end else if (walking) begin
         if (!wb_valid) begin
            val_q[w_set][w_way]   <= 1'b0;
            dirty_q[w_set][w_way] <= 1'b0;
            lock_q[w_set][w_way]  <= 1'b0;
            rank_q[w_set][w_way]  <= '0;
            if (walk_idx == '1) walking <= 1'b0;
            walk_idx <= walk_idx + 1'b1;
         end
      end else if (accept) begin
         if (op == OP_INVAL_ALL) begin
            walking    <= 1'b1;
            walk_flush <= req_flush;
            walk_idx   <= '0;
         end else begin
            if (rank_we) rank_q[l_set] <= new_ranks;
            if (alloc) begin
               val_q[l_set][tw]   <= 1'b1;
               dirty_q[l_set][tw] <= is_store;
               lock_q[l_set][tw]  <= (op == OP_LOCK);
            end else if (hit) begin
               case (op)
                  OP_STORE:  if (copy_back) dirty_q[l_set][tw] <= 1'b1;
                  OP_LOCK:   lock_q[l_set][tw] <= 1'b1;
                  OP_UNLOCK: lock_q[l_set][tw] <= 1'b0;
                  OP_INVAL: begin
                     val_q[l_set][tw]   <= 1'b0;
                     dirty_q[l_set][tw] <= 1'b0;
                     lock_q[l_set][tw]  <= 1'b0;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // write-back and refill handshakes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid   <= 1'b0;
         wb_addr    <= '0;
         fill_valid <= 1'b0;
         fill_wait  <= 1'b0;
         fill_addr  <= '0;
         fill_way   <= '0;
      end else begin
         if (walking && !wb_valid) begin
            if (walk_flush && val_q[w_set][w_way] && dirty_q[w_set][w_way]) begin
               wb_valid <= 1'b1;
               wb_addr  <= {tag_q[w_set][w_way], w_set};
            end
         end else if (accept && op != OP_INVAL_ALL) begin
            wb_valid   <= wb_alloc | wb_inval;
            wb_addr    <= wb_alloc ? {tag_q[l_set][victim], l_set} : req_line;
            fill_valid <= alloc & ~wb_alloc;
            fill_wait  <= alloc & wb_alloc;
            fill_addr  <= req_line;
            fill_way   <= victim;
         end
         if (wb_valid && wb_ready) begin
            wb_valid <= 1'b0;
            if (fill_wait) begin
               fill_valid <= 1'b1;
               fill_wait  <= 1'b0;
            end
         end
         if (fill_valid && fill_ready) fill_valid <= 1'b0;
      end
   end

   // response and counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_way      <= '0;
         rsp_bypass   <= 1'b0;
         rsp_line_wr  <= 1'b0;
         rsp_mem_wr   <= 1'b0;
         hit_count    <= '0;
         access_count <= '0;
      end else begin
         rsp_valid   <= accept;
         rsp_hit     <= accept & hit;
         rsp_way     <= (accept & (hit | alloc)) ? tw : '0;
         rsp_bypass  <= accept & bypass;
         rsp_line_wr <= accept & line_wr;
         rsp_mem_wr  <= accept & mem_wr;
         if (accept && (op == OP_LOAD || op == OP_STORE)) begin
            if (access_count != '1) access_count <= access_count + 1'b1;
            if (hit && hit_count != '1) hit_count <= hit_count + 1'b1;
         end
      end
   end

   // assertions
   p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> !rsp_valid);
   p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));
   p_fill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr) && $stable(fill_way)));
   p_fill_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !wb_valid);
   p_bypass_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_bypass) |-> (!rsp_hit && !rsp_line_wr && !fill_valid));
   p_hits_le_acc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hit_count <= access_count);
   p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));
endmodule

// File: tb/sim_cache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_cache_tag_ctrl;
   localparam int SETS = 128;
   localparam int WAYS = 2;
   localparam int CW   = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [26:0] req_line = '0;
   logic        req_flush = 1'b0;
   logic        cb = 1'b1;
   logic        ow = 1'b0;
   logic        busy, rsp_valid, rsp_hit, rsp_bypass, rsp_line_wr, rsp_mem_wr;
   logic [0:0]  rsp_way, fill_way;
   logic        wb_valid, fill_valid;
   logic        wb_ready = 1'b0;
   logic        fill_ready = 1'b0;
   logic [26:0] wb_addr, fill_addr;
   logic [CW-1:0] hit_count, access_count;

   always #10 clk = ~clk;

   cache_tag_ctrl #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_line(req_line), .req_flush(req_flush), .copy_back(cb), .one_way(ow),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
      .rsp_bypass(rsp_bypass), .rsp_line_wr(rsp_line_wr), .rsp_mem_wr(rsp_mem_wr),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
      .fill_ready(fill_ready), .hit_count(hit_count), .access_count(access_count)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   int  m_tag  [SETS][WAYS];
   int  m_rank [SETS][WAYS];
   bit  m_val  [SETS][WAYS];
   bit  m_dirty[SETS][WAYS];
   bit  m_lock [SETS][WAYS];
   int  m_acc = 0;
   int  m_hits = 0;
   logic [26:0] wbq[$];
   logic [26:0] fillq[$];
   int          fwq[$];
   int  e_hit, e_way, e_byp, e_lw, e_mw;

   task automatic chk(input string r, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   function automatic logic [26:0] la(input int t, input int s);
      return {t[19:0], s[6:0]};
   endfunction

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   task automatic touch(input int s, input int w);
      int old = m_rank[s][w];
      for (int x = 0; x < WAYS; x++)
         if (x != w && m_rank[s][x] > old) m_rank[s][x]--;
      m_rank[s][w] = WAYS;
   endtask

   task automatic demote(input int s, input int w);
      int old = m_rank[s][w];
      for (int x = 0; x < WAYS; x++)
         if (x != w && m_rank[s][x] != 0 && m_rank[s][x] < old) m_rank[s][x]++;
      m_rank[s][w] = 0;
   endtask

   task automatic model(input int op, input logic [26:0] a, input bit fl);
      int s, t, dw, hw, v, best;
      bit en;
      s = int'(a[6:0]); t = int'(a[26:7]); dw = int'(a[7]);
      hw = -1; v = -1; best = 1000;
      e_hit = 0; e_way = 0; e_byp = 0; e_lw = 0; e_mw = 0;
      if (op == 5) begin
         for (int s2 = 0; s2 < SETS; s2++)
            for (int w = 0; w < WAYS; w++) begin
               if (fl && m_val[s2][w] && m_dirty[s2][w]) wbq.push_back(la(m_tag[s2][w], s2));
               m_val[s2][w] = 0; m_dirty[s2][w] = 0; m_lock[s2][w] = 0; m_rank[s2][w] = 0;
            end
         return;
      end
      for (int w = 0; w < WAYS; w++) begin
         en = !ow || (w == dw);
         if (en && m_val[s][w] && m_tag[s][w] == t && hw < 0) hw = w;
         if (en && !m_lock[s][w] && m_rank[s][w] < best) begin v = w; best = m_rank[s][w]; end
      end
      e_hit = (hw >= 0);
      if (op <= 2) begin
         if (op <= 1) begin
            m_acc = sat(m_acc + 1);
            if (e_hit) m_hits = sat(m_hits + 1);
         end
         if (hw >= 0) begin
            e_way = hw; touch(s, hw);
            if (op == 1) begin e_lw = 1; e_mw = !cb; if (cb) m_dirty[s][hw] = 1; end
            if (op == 2) m_lock[s][hw] = 1;
         end else if (v < 0) begin
            e_byp = 1; if (op == 1) e_mw = 1;
         end else if (op == 1 && !cb) begin
            e_mw = 1;
         end else begin
            e_way = v;
            if (m_val[s][v] && m_dirty[s][v] && cb) wbq.push_back(la(m_tag[s][v], s));
            fillq.push_back(a); fwq.push_back(v);
            m_tag[s][v] = t; m_val[s][v] = 1; m_dirty[s][v] = (op == 1); m_lock[s][v] = (op == 2);
            touch(s, v);
            if (op == 1) e_lw = 1;
         end
      end else if (op == 3) begin
         if (hw >= 0) begin e_way = hw; m_lock[s][hw] = 0; end
      end else if (op == 4) begin
         if (hw >= 0) begin
            e_way = hw;
            if (fl && m_dirty[s][hw]) wbq.push_back(a);
            demote(s, hw);
            m_val[s][hw] = 0; m_dirty[s][hw] = 0; m_lock[s][hw] = 0;
         end
      end
   endtask

   // act as refill engine and compare handshake traffic with the model
   task automatic serve();
      int n = 0;
      while (busy === 1'b1 && n < 3000) begin
         if (wb_valid === 1'b1) begin
            if (wbq.size() == 0) chk("R7", "unexpected write-back", 1, 0);
            else chk("R7", "wb_addr", wb_addr, wbq.pop_front());
            wb_ready = 1'b1; @(negedge clk); wb_ready = 1'b0;
         end else if (fill_valid === 1'b1) begin
            chk("R11", "write-back before refill", wbq.size(), 0);
            if (fillq.size() == 0) chk("R7", "unexpected refill", 1, 0);
            else begin
               chk("R7", "fill_addr", fill_addr, fillq.pop_front());
               chk("R3", "fill_way", fill_way, fwq.pop_front());
            end
            fill_ready = 1'b1; @(negedge clk); fill_ready = 1'b0;
         end else @(negedge clk);
         n++;
      end
      chk("R11", "pending write-backs", wbq.size(), 0);
      chk("R11", "pending refills", fillq.size(), 0);
      chk("R11", "busy released", busy, 0);
   endtask

   task automatic do_req(input string r, input int op, input logic [26:0] a, input bit fl);
      req_valid = 1'b1; req_op = op[2:0]; req_line = a; req_flush = fl;
      model(op, a, fl);
      @(negedge clk);
      req_valid = 1'b0;
      chk(r, "rsp_valid", rsp_valid, 1);
      chk(r, "rsp_hit", rsp_hit, e_hit);
      chk(r, "rsp_way", rsp_way, e_way);
      chk(r, "rsp_bypass", rsp_bypass, e_byp);
      chk(r, "rsp_line_wr", rsp_line_wr, e_lw);
      chk(r, "rsp_mem_wr", rsp_mem_wr, e_mw);
      chk("R12", "access_count", access_count, m_acc);
      chk("R12", "hit_count", hit_count, m_hits);
      serve();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "rsp_valid", rsp_valid, 0);
      chk("R1", "wb_valid", wb_valid, 0);
      chk("R1", "fill_valid", fill_valid, 0);
      chk("R1", "hit_count", hit_count, 0);
      chk("R1", "access_count", access_count, 0);

      // R2 / R3 / R4 basic fills, hits and recency order
      do_req("R2", 0, la(1, 3), 0);
      do_req("R2", 0, la(1, 3), 0);
      do_req("R3", 0, la(2, 3), 0);
      do_req("R4", 0, la(1, 3), 0);
      do_req("R4", 0, la(3, 3), 0);

      // R6 / R7 copy-back stores, dirty eviction
      do_req("R6", 1, la(3, 3), 0);
      do_req("R6", 1, la(4, 3), 0);
      do_req("R7", 1, la(5, 3), 0);

      // R6 / R7 write-through behaviour
      cb = 1'b0;
      do_req("R6", 1, la(5, 3), 0);
      do_req("R6", 1, la(9, 3), 0);
      do_req("R7", 0, la(6, 3), 0);
      cb = 1'b1;

      // R8 / R3 locking
      do_req("R8", 2, la(7, 10), 0);
      do_req("R8", 2, la(8, 10), 0);
      do_req("R3", 0, la(9, 10), 0);
      do_req("R3", 1, la(9, 10), 0);
      do_req("R8", 3, la(7, 10), 0);
      do_req("R8", 0, la(9, 10), 0);

      // R5 invalidation and demotion
      do_req("R5", 1, la(10, 20), 0);
      do_req("R5", 0, la(11, 20), 0);
      do_req("R5", 4, la(11, 20), 1);
      do_req("R5", 0, la(12, 20), 0);
      do_req("R5", 4, la(10, 20), 1);
      do_req("R5", 4, la(99, 20), 1);
      do_req("R5", 0, la(10, 20), 0);

      // R11 requests ignored while busy
      req_valid = 1'b1; req_op = 3'd0; req_line = la(18, 60); req_flush = 1'b0;
      model(0, la(18, 60), 0);
      @(negedge clk);
      chk("R11", "first rsp_valid", rsp_valid, 1);
      req_line = la(19, 60);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11", "rsp_valid while busy", rsp_valid, 0);
      chk("R11", "fill held", fill_valid, 1);
      @(negedge clk);
      chk("R11", "fill_addr held", fill_addr, la(18, 60));
      serve();
      do_req("R11", 0, la(19, 60), 0);

      // R10 direct-mapped mode
      ow = 1'b1;
      do_req("R10", 0, la(13, 40), 0);
      do_req("R10", 0, la(13, 40), 0);
      do_req("R10", 0, la(14, 40), 0);
      do_req("R10", 0, la(15, 40), 0);
      do_req("R10", 0, la(13, 40), 0);
      ow = 1'b0;

      // R9 invalidate-all with flush
      do_req("R9", 1, la(16, 50), 0);
      do_req("R9", 1, la(17, 51), 0);
      do_req("R9", 5, '0, 1);
      do_req("R9", 0, la(16, 50), 0);
      do_req("R9", 0, la(5, 3), 0);

      // R12 saturation of both counters
      for (int i = 0; i < 20; i++) do_req("R12", 0, la(16, 50), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule